// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block is a small register with a parallel-load path and a right-shift path. Each path has its own clock input. A mode level decides which path is live: with mode high, a falling edge on the load clock copies the parallel word into the register; with mode low, a falling edge on the shift clock moves the serial bit into the first stage and every other stage one place down the chain. The other clock is ignored while its path is not selected.

Both clock inputs are treated as ordinary data levels and sampled in one system clock domain. Each input has its own tracking flop, and an active edge is recognised when that flop holds 1 and the current sample is 0. The register has no left-shift path of its own. To shift left, wire each parallel input from the next stage's output, feed the new serial bit into the last parallel input, and pulse the load clock in load mode.

Top module: `dcsr_shift_reg`

## Requirements
- R1: With `mode_i` = 1, a high-to-low transition on `ld_clk_i` loads `par_i` into `q_o` on the system edge that samples the low level (`par_i[0]` goes to `q_o[0]`, the first stage).
- R2: With `mode_i` = 0, a high-to-low transition on `sh_clk_i` sets `q_o[0]` to `ser_i` and `q_o[i]` to the old `q_o[i-1]` for i ≥ 1.
- R3: While `mode_i` = 1, a falling edge on `sh_clk_i` leaves `q_o` unchanged.
- R4: While `mode_i` = 0, a falling edge on `ld_clk_i` leaves `q_o` unchanged.
- R5: With no enabled falling edge, `q_o` holds its value whatever `par_i`, `ser_i` and `mode_i` do.
- R6: A low-to-high transition on either clock input causes no operation.
- R7: If both clock inputs fall in the same system cycle, only the operation chosen by `mode_i` takes place.
- R8: The edge trackers follow their inputs in every mode, so a clock input that fell while its path was disabled does not act when `mode_i` later selects that path.
- R9: A synchronous active-low reset clears `q_o` to 0 and loads each tracker with the level its clock input has at that edge. A clock input held low through reset therefore causes no operation after reset is released.
- R10: In load mode, with `par_i[i]` = `q_o[i+1]` for i < 3 and `par_i[3]` = the new serial bit, one load-clock falling edge shifts left, and `q_o[3]` ends up holding the new bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 selects parallel load, 0 selects right shift |
| ser_i | input | 1 | Serial bit that enters stage 0 on a right shift |
| par_i | input | WIDTH | Parallel data; bit i goes to stage i |
| ld_clk_i | input | 1 | Load clock level; its falling edge is active |
| sh_clk_i | input | 1 | Shift clock level; its falling edge is active |
| q_o | output | WIDTH | Register state; bit 0 is the first stage |

## Verification
The assertions check every cycle that an enabled load edge produces the parallel word, that an enabled shift edge produces the shifted word, that a cycle with no enabled edge leaves the state unchanged even when the other clock falls, and that reset clears the register. Only the bench scenarios can show the behaviour that depends on tracker history: a rising edge doing nothing, a mode change after a disabled edge not acting, a clock input held low through reset not acting after release, and the left shift built from external feedback.

// File: rtl/dcsr_pkg.sv
// Package: shared constants for the dual-clock shift register.
// Assumes: channel indices are used to pick edge-detector lanes.
package dcsr_pkg;
    localparam int unsigned NUM_CLK_CH = 2;
    localparam int unsigned CH_LOAD    = 0;
    localparam int unsigned CH_SHIFT   = 1;

    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } op_mode_e;
endpackage

// File: rtl/dcsr_fall_detect.sv
// Module: per-channel falling-edge detector for level inputs sampled in clk.
// Assumes: inputs are already synchronous to clk; trackers are loaded with
// the sampled level during reset as well, so no edge appears at release.
module dcsr_fall_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        // Track the previous sample; the reset branch takes the live level too.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= lvl_i[g];
            else        prev_q[g] <= lvl_i[g];
        end

        // High previous sample and low current sample means a falling edge.
        always_comb fall_o[g] = prev_q[g] & ~lvl_i[g];
    end
endmodule

// File: rtl/dcsr_stage_core.sv
// Module: register stages with a mode-gated choice between load and right shift.
// Assumes: fall strobes last one clk cycle; stage 0 is the serial entry stage.
module dcsr_stage_core
    import dcsr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ld_fall_i,
    input  logic             sh_fall_i,
    output logic [WIDTH-1:0] q_o
);
    op_mode_e         mode_sel;
    logic             do_load;
    logic             do_shift;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] stage_q;

    // Decode the mode level and gate each edge strobe with it.
    always_comb begin
        mode_sel = op_mode_e'(mode_i);
        do_load  = (mode_sel == OP_LOAD)  && ld_fall_i;
        do_shift = (mode_sel == OP_SHIFT) && sh_fall_i;
    end

    // Build the right-shifted word: serial bit in at stage 0.
    always_comb begin
        shifted[0] = ser_i;
        for (int i = 1; i < WIDTH; i++) shifted[i] = stage_q[i-1];
    end

    // State update: clear, load, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (do_load)  stage_q <= par_i;
        else if (do_shift) stage_q <= shifted;
    end

    assign q_o = stage_q;
endmodule

// File: rtl/dcsr_shift_reg.sv
// Module: top level of the dual-clock mode-selected shift register.
// Assumes: ld_clk_i and sh_clk_i are slow level signals sampled by clk.
module dcsr_shift_reg
    import dcsr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ld_clk_i,
    input  logic             sh_clk_i,
    output logic [WIDTH-1:0] q_o
);
    logic [NUM_CLK_CH-1:0] clk_lvl;
    logic [NUM_CLK_CH-1:0] clk_fall;
    logic                  ld_fall_w;
    logic                  sh_fall_w;

    // Gather the two clock inputs into detector lanes.
    always_comb begin
        clk_lvl           = '0;
        clk_lvl[CH_LOAD]  = ld_clk_i;
        clk_lvl[CH_SHIFT] = sh_clk_i;
    end

    dcsr_fall_detect #(.N(NUM_CLK_CH)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (clk_lvl),
        .fall_o (clk_fall)
    );

    // Split the strobes back out per operation.
    always_comb begin
        ld_fall_w = clk_fall[CH_LOAD];
        sh_fall_w = clk_fall[CH_SHIFT];
    end

    dcsr_stage_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .ser_i     (ser_i),
        .par_i     (par_i),
        .ld_fall_i (ld_fall_w),
        .sh_fall_i (sh_fall_w),
        .q_o       (q_o)
    );
endmodule

// File: rtl/dcsr_checker.sv
// Module: property checker bound to dcsr_shift_reg.
// Assumes: fall strobes from the top are the detector outputs.
module dcsr_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic             ser_i,
    input logic [WIDTH-1:0] par_i,
    input logic             ld_fall,
    input logic             sh_fall,
    input logic [WIDTH-1:0] q_o
);
    // R1: enabled load edge yields the parallel word.
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && ld_fall) |=> (q_o == $past(par_i)));

    // R2: enabled shift edge yields the right-shifted word.
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && sh_fall) |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)}));

    // R3: shift clock in load mode with no load edge leaves state.
    a_r3_shift_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && sh_fall && !ld_fall) |=> $stable(q_o));

    // R4: load clock in shift mode with no shift edge leaves state.
    a_r4_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && ld_fall && !sh_fall) |=> $stable(q_o));

    // R5: no enabled edge means hold.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !((mode_i && ld_fall) || (!mode_i && sh_fall)) |=> $stable(q_o));

    // R9: reset clears the register.
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0));
endmodule

bind dcsr_shift_reg dcsr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .ld_fall (ld_fall_w),
    .sh_fall (sh_fall_w),
    .q_o     (q_o)
);

// File: tb/sim_dcsr_shift_reg.sv
`timescale 1ns/1ps
// Directed bench for dcsr_shift_reg: one task per scenario.
module sim_dcsr_shift_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b1;
    logic       ser_i = 1'b0;
    logic [3:0] par_i = 4'h0;
    logic       ld_clk_i = 1'b1;
    logic       sh_clk_i = 1'b1;
    logic [3:0] q_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_q;

    always #2.5 clk = ~clk;

    dcsr_shift_reg #(.WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ser_i(ser_i),
        .par_i(par_i), .ld_clk_i(ld_clk_i), .sh_clk_i(sh_clk_i), .q_o(q_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q_o=%b expected=%b", tag, act, exp);
        end
    endtask

    // Falling edge then rise on the load clock; checks after the fall.
    task automatic ld_fall_then_rise(input string tag, input logic [3:0] exp);
        ld_clk_i = 1'b0; step(); check(tag, q_o, exp);
        ld_clk_i = 1'b1; step();
    endtask

    task automatic sh_fall_then_rise(input string tag, input logic [3:0] exp);
        sh_clk_i = 1'b0; step(); check(tag, q_o, exp);
        sh_clk_i = 1'b1; step();
    endtask

    task automatic t_reset();
        // R9: load clock held low through reset, in load mode.
        rst_n = 1'b0; ld_clk_i = 1'b0; mode_i = 1'b1; par_i = 4'hF;
        step(); step(); step();
        check("R9 reset clear", q_o, 4'h0);
        rst_n = 1'b1; step(); step();
        check("R9 low clock at release", q_o, 4'h0);
        ld_clk_i = 1'b1; step();
        check("R6 rise after reset", q_o, 4'h0);
        exp_q = 4'h0;
    endtask

    task automatic t_load();
        mode_i = 1'b1;
        foreach (par_i[i]) begin end
        par_i = 4'b1010; exp_q = 4'b1010;
        ld_clk_i = 1'b0; step(); check("R1 load A", q_o, exp_q);
        par_i = 4'b0101; ld_clk_i = 1'b1; step();
        check("R6 rising load no effect", q_o, exp_q);
        exp_q = 4'b0101; ld_fall_then_rise("R1 load B", exp_q);
        par_i = 4'b0001; exp_q = 4'b0001; ld_fall_then_rise("R1 load bit0 to stage0", exp_q);
    endtask

    task automatic t_shift();
        mode_i = 1'b0;
        ser_i = 1'b1; exp_q = {exp_q[2:0], 1'b1}; sh_fall_then_rise("R2 shift 1", exp_q);
        ser_i = 1'b0; exp_q = {exp_q[2:0], 1'b0}; sh_fall_then_rise("R2 shift 0", exp_q);
        ser_i = 1'b1; exp_q = {exp_q[2:0], 1'b1}; sh_fall_then_rise("R2 shift 1 again", exp_q);
        sh_clk_i = 1'b0; step(); sh_clk_i = 1'b1; ser_i = 1'b0; step();
        exp_q = {exp_q[2:0], 1'b1};
        check("R6 rising shift no effect", q_o, exp_q);
    endtask

    task automatic t_ignore();
        mode_i = 1'b1; ser_i = 1'b1;
        sh_fall_then_rise("R3 shift clock in load mode", exp_q);
        mode_i = 1'b0; par_i = ~exp_q;
        ld_fall_then_rise("R4 load clock in shift mode", exp_q);
    endtask

    task automatic t_hold();
        for (int k = 0; k < 6; k++) begin
            par_i = 4'(k * 5); ser_i = k[0]; mode_i = k[1];
            step();
        end
        check("R5 hold with data activity", q_o, exp_q);
    endtask

    task automatic t_both();
        mode_i = 1'b1; par_i = 4'b0110; exp_q = 4'b0110;
        ld_clk_i = 1'b0; sh_clk_i = 1'b0; step();
        check("R7 both edges, load mode", q_o, exp_q);
        ld_clk_i = 1'b1; sh_clk_i = 1'b1; step();
        mode_i = 1'b0; ser_i = 1'b1; par_i = 4'b1001; exp_q = {exp_q[2:0], 1'b1};
        ld_clk_i = 1'b0; sh_clk_i = 1'b0; step();
        check("R7 both edges, shift mode", q_o, exp_q);
        ld_clk_i = 1'b1; sh_clk_i = 1'b1; step();
    endtask

    task automatic t_mode_change();
        mode_i = 1'b1; ser_i = 1'b0;
        sh_clk_i = 1'b0; step();
        check("R8 disabled shift edge", q_o, exp_q);
        mode_i = 1'b0; step(); step();
        check("R8 mode change after disabled edge", q_o, exp_q);
        sh_clk_i = 1'b1; step();
        par_i = 4'hF; ld_clk_i = 1'b0; step();
        mode_i = 1'b1; step(); step();
        check("R8 switch to load with clock already low", q_o, exp_q);
        ld_clk_i = 1'b1; step();
    endtask

    task automatic t_left();
        mode_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ser_i = (k != 1);
            par_i = {ser_i, q_o[3], q_o[2], q_o[1]};
            exp_q = {ser_i, exp_q[3:1]};
            ld_fall_then_rise("R10 left shift via feedback", exp_q);
        end
        check("R10 last stage holds new bit", {3'b000, q_o[3]}, 4'b0001);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: q_o=%b expected=done", q_o);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_load();
        t_shift();
        t_ignore();
        t_hold();
        t_both();
        t_mode_change();
        t_left();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule